// File: doc/BRIEF.md
# Real-Time Clock Timekeeper Core

This block keeps calendar time in packed BCD: seconds, minutes, hours, day of week, day of month, month and two-digit year, plus a century flag. A one-cycle reference tick, nominally at 32,768 Hz, feeds a sub-second divider. That divider produces one step of the time chain per second. Carries ripple from seconds up to years in the same cycle. The day of month wraps at the length of the current month, and February has 29 days in years divisible by four.

Software reaches eight byte-wide registers through an address bus with separate read and write strobes. A halt bit in the seconds register stops the oscillator, which freezes the time and the test divider. The century flag flips at the 99-to-00 year wrap only when its enable bit is set. One output pin shows either a square wave (512 Hz at the default reference) or a static level taken from the control register.

Top module: `rtc_timekeeper`

## Requirements
- R1: Address 0 holds {halt[7], seconds[6:0]}. Address 1 holds minutes in bits [6:0]. Address 2 holds {century enable[7], century flag[6], hours[5:0]}. Address 3 holds the day of week in bits [2:0]. Address 4 holds the day of month in bits [5:0]. Address 5 holds the month in bits [4:0]. Address 6 holds the year in bits [7:0]. Address 7 holds {output level[7], test enable[6]}. Bits with no field read as 0. After reset the registers read 00,00,00,01,01,01,00,80 for addresses 0 to 7.
- R2: While not halted, seconds advance by one after every REF_HZ reference ticks. Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00.
- R3: On each day carry, the day of week steps from 7 back to 1; otherwise it increments.
- R4: On a day carry, the day of month wraps to 01 after 30 in April, June, September and November, and after 31 in the other months. In February it wraps after 29 when the BCD year is divisible by 4 and after 28 otherwise.
- R5: On a month carry, the month wraps from 12 to 01 and the year increments. The year wraps from 99 to 00.
- R6: When the year wraps from 99 to 00, the century flag inverts if century enable is 1. The flag never changes on its own while century enable is 0.
- R7: While the halt bit is 1, no time field changes. After a write clears the halt bit, the next seconds step comes exactly REF_HZ ticks later.
- R8: A write to any of addresses 0 to 6 clears the sub-second divider. The next seconds step then comes exactly REF_HZ ticks after the write.
- R9: With test enable at 1, the output pin is 0 right after the control write. It then toggles every REF_HZ/(2*TEST_HZ) reference ticks.
- R10: With test enable at 0, the output pin equals the output-level bit. The pin is therefore low when both bits are 0 and high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference oscillator period |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data for addr while rd_en is 1, else 0 |
| out_pin | output | 1 | Test square wave or static output level |

## Verification
The bench sets the calendar to 23:59:59 on the last day of December 99 with century enable set. One second later every field must wrap in the same cycle and the century flag must invert. A broken carry chain would leave the upper fields stale, and a wrong enable test would flip the flag when it must hold. The February tests use a leap year and a non-leap year, and the 30-day test uses April; a wrong month-length decode shows up as a missing or extra day. The bench also checks the seconds count a tick early and then on the exact tick, both after a mid-second write and after the halt bit is cleared, so a divider that is not cleared makes the second come early. The pin test checks the phase of the test wave around its toggle tick, and it checks that the level bit is driven low.

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper #(
  parameter int REF_HZ  = 32768,
  parameter int TEST_HZ = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       out_pin
);
  localparam int DIV_W  = $clog2(REF_HZ);
  localparam int HALF   = REF_HZ / (2 * TEST_HZ);
  localparam int HALF_W = $clog2(HALF + 1);
  localparam logic [DIV_W-1:0]  DIV_TOP  = DIV_W'(REF_HZ - 1);
  localparam logic [HALF_W-1:0] HALF_TOP = HALF_W'(HALF - 1);

  logic             halt, cen_en, cen, olvl, ftest, tq;
  logic [6:0]       sec, min;
  logic [5:0]       hr, date;
  logic [2:0]       wd;
  logic [4:0]       mon;
  logic [7:0]       yr;
  logic [DIV_W-1:0] sub;
  logic [HALF_W-1:0] tcnt;

  function automatic logic [7:0] bcd_up(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  wire time_wr = wr_en && (addr != 3'd7);
  wire ctrl_wr = wr_en && (addr == 3'd7);
  wire run     = ref_tick && !halt;
  wire s_pulse = run && (sub == DIV_TOP) && !time_wr;
  wire c_min   = s_pulse && (sec == 7'h59);
  wire c_hr    = c_min && (min == 7'h59);
  wire c_day   = c_hr && (hr == 6'h23);
  wire leap    = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                       : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);

  logic [5:0] last_day;
  always_comb begin
    case (mon)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  end

  wire c_mon  = c_day && (date == last_day);
  wire c_yr   = c_mon && (mon == 5'h12);
  wire y_wrap = c_yr && (yr == 8'h99);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt <= 1'b0; sec <= '0; min <= '0;
      cen_en <= 1'b0; cen <= 1'b0; hr <= '0;
      wd <= 3'd1; date <= 6'h01; mon <= 5'h01; yr <= '0;
      olvl <= 1'b1; ftest <= 1'b0;
      sub <= '0; tcnt <= '0; tq <= 1'b0;
    end else begin
      if (time_wr)  sub <= '0;
      else if (run) sub <= (sub == DIV_TOP) ? '0 : sub + 1'b1;

      if (ctrl_wr) begin
        tcnt <= '0; tq <= 1'b0;
      end else if (run) begin
        tcnt <= (tcnt == HALF_TOP) ? '0 : tcnt + 1'b1;
        if (tcnt == HALF_TOP) tq <= ~tq;
      end

      if (s_pulse) sec  <= (sec == 7'h59) ? '0 : 7'(bcd_up({1'b0, sec}));
      if (c_min)   min  <= (min == 7'h59) ? '0 : 7'(bcd_up({1'b0, min}));
      if (c_hr)    hr   <= (hr == 6'h23) ? '0 : 6'(bcd_up({2'b0, hr}));
      if (c_day)   wd   <= (wd == 3'd7) ? 3'd1 : wd + 3'd1;
      if (c_day)   date <= (date == last_day) ? 6'h01 : 6'(bcd_up({2'b0, date}));
      if (c_mon)   mon  <= (mon == 5'h12) ? 5'h01 : 5'(bcd_up({3'b0, mon}));
      if (c_yr)    yr   <= (yr == 8'h99) ? 8'h00 : bcd_up(yr);
      if (y_wrap && cen_en) cen <= ~cen;

      if (wr_en) begin
        case (addr)
          3'd0: begin halt <= wr_data[7]; sec <= wr_data[6:0]; end
          3'd1: min <= wr_data[6:0];
          3'd2: begin cen_en <= wr_data[7]; cen <= wr_data[6]; hr <= wr_data[5:0]; end
          3'd3: wd <= wr_data[2:0];
          3'd4: date <= wr_data[5:0];
          3'd5: mon <= wr_data[4:0];
          3'd6: yr <= wr_data;
          default: begin olvl <= wr_data[7]; ftest <= wr_data[6]; end
        endcase
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_en) begin
      case (addr)
        3'd0: rd_data = {halt, sec};
        3'd1: rd_data = {1'b0, min};
        3'd2: rd_data = {cen_en, cen, hr};
        3'd3: rd_data = {5'b0, wd};
        3'd4: rd_data = {2'b0, date};
        3'd5: rd_data = {3'b0, mon};
        3'd6: rd_data = yr;
        default: rd_data = {olvl, ftest, 6'b0};
      endcase
    end
  end

  assign out_pin = ftest ? tq : olvl;

  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(hr) && $stable(yr)));
  p_sec_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ref_tick) |=> $stable(sec));
  p_cen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_en && !wr_en) |=> $stable(cen));
  p_year_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_yr && yr == 8'h99 && !wr_en) |=> (yr == 8'h00 && mon == 5'h01));
  p_div_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> (sub == '0));
  p_out_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ftest && !olvl) |-> !out_pin);
endmodule

// File: tb/rtc_timekeeper_tb.sv
module rtc_timekeeper_tb_top;
  localparam int REF_HZ = 64;
  localparam int TEST_HZ = 8;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic out_pin;
  logic pin_chk = 1'b0;
  int n_tests = 0, n_fail = 0;

  typedef struct { bit is_pin; logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  rtc_timekeeper #(.REF_HZ(REF_HZ), .TEST_HZ(TEST_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .out_pin(out_pin));

  always @(negedge clk) begin
    if (rd_en || pin_chk) begin
      item_t it;
      logic [7:0] act;
      n_tests++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty: act=%h exp=none", rd_data);
      end else begin
        it = sb.pop_front();
        act = it.is_pin ? {7'b0, out_pin} : rd_data;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: act=%h exp=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2; addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #2; wr_en = 1'b0;
  endtask

  task automatic chk_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #2; sb.push_back('{1'b0, e, tag}); addr = a; rd_en = 1'b1;
    @(posedge clk); #2; rd_en = 1'b0;
  endtask

  task automatic chk_pin(input logic e, input string tag);
    @(posedge clk); #2; sb.push_back('{1'b1, {7'b0, e}, tag}); pin_chk = 1'b1;
    @(posedge clk); #2; pin_chk = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; ref_tick = 1'b1;
      @(posedge clk); #2; ref_tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] s, m, h, w, d, mo, y);
    wr(0, s); wr(1, m); wr(2, h); wr(3, w); wr(4, d); wr(5, mo); wr(6, y);
  endtask

  initial begin
    #4_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset values and layout
    chk_reg(0, 8'h00, "R1 sec"); chk_reg(1, 8'h00, "R1 min"); chk_reg(2, 8'h00, "R1 hr");
    chk_reg(3, 8'h01, "R1 wd"); chk_reg(4, 8'h01, "R1 date"); chk_reg(5, 8'h01, "R1 mon");
    chk_reg(6, 8'h00, "R1 yr"); chk_reg(7, 8'h80, "R1 ctrl");
    chk_pin(1'b1, "R10 reset level");
    // R2 one step per REF_HZ ticks
    tick(REF_HZ - 1); chk_reg(0, 8'h00, "R2 early");
    tick(1);          chk_reg(0, 8'h01, "R2 step");
    // R2 R3 R4 R5 R6 full wrap with century flip
    set_time(8'h59, 8'h59, 8'hA3, 8'h07, 8'h31, 8'h12, 8'h99);
    tick(REF_HZ);
    chk_reg(0, 8'h00, "R2 sec wrap"); chk_reg(1, 8'h00, "R2 min wrap");
    chk_reg(2, 8'hC0, "R6 century flip");  chk_reg(3, 8'h01, "R3 wd wrap");
    chk_reg(4, 8'h01, "R4 date wrap");     chk_reg(5, 8'h01, "R5 mon wrap");
    chk_reg(6, 8'h00, "R5 yr wrap");
    // R6 flag inverts back with enable, holds without
    set_time(8'h59, 8'h59, 8'hE3, 8'h02, 8'h31, 8'h12, 8'h99);
    tick(REF_HZ); chk_reg(2, 8'h80, "R6 flip back");
    set_time(8'h59, 8'h59, 8'h63, 8'h02, 8'h31, 8'h12, 8'h99);
    tick(REF_HZ); chk_reg(2, 8'h40, "R6 hold disabled");
    // R4 month lengths
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    tick(REF_HZ); chk_reg(4, 8'h29, "R4 leap feb"); chk_reg(5, 8'h02, "R4 leap feb mon");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
    tick(REF_HZ); chk_reg(4, 8'h01, "R4 plain feb"); chk_reg(5, 8'h03, "R4 plain feb mon");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h23);
    tick(REF_HZ); chk_reg(4, 8'h01, "R4 april"); chk_reg(5, 8'h05, "R4 april mon");
    set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h30, 8'h01, 8'h23);
    tick(REF_HZ); chk_reg(4, 8'h31, "R4 january"); chk_reg(3, 8'h07, "R3 wd step");
    // R7 halt
    wr(0, 8'h90); tick(3 * REF_HZ);
    chk_reg(0, 8'h90, "R7 halted"); chk_reg(1, 8'h00, "R7 halted min");
    wr(0, 8'h10); tick(REF_HZ - 1); chk_reg(0, 8'h10, "R7 restart early");
    tick(1); chk_reg(0, 8'h11, "R7 restart step");
    // R8 write clears divider
    tick(40); wr(1, 8'h05);
    tick(REF_HZ - 1); chk_reg(0, 8'h11, "R8 early");
    tick(1); chk_reg(0, 8'h12, "R8 step");
    // R9 test wave, half period REF_HZ/(2*TEST_HZ)=4
    wr(7, 8'h40); chk_reg(7, 8'h40, "R1 ctrl readback"); chk_pin(1'b0, "R9 start");
    tick(3); chk_pin(1'b0, "R9 before toggle");
    tick(1); chk_pin(1'b1, "R9 toggle high");
    tick(3); chk_pin(1'b1, "R9 hold high");
    tick(1); chk_pin(1'b0, "R9 toggle low");
    // R10 static level
    wr(7, 8'h00); chk_pin(1'b0, "R10 low");
    wr(7, 8'h80); chk_pin(1'b1, "R10 high");
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule